// File: doc/BRIEF.md
# Virtual Link Frame Regulator

This block shapes the transmit traffic of one virtual link in a dual-network switched Ethernet. An application queue offers frame descriptors, each a length with a one-cycle request strobe. The block stores one accepted descriptor. It releases that descriptor only after a minimum spacing has passed since the start of the previous release. The spacing is 2^k milliseconds, with k chosen by a 3-bit configuration input. A free-running one-microsecond tick input provides the time base.

Each release carries a one-byte sequence number. The same frame and the same number appear on both redundant transmit ports in the same cycle. The block reports the number of bytes the frame occupies on the wire. A hold input stands for contention at the output. While it is asserted, releases are deferred, and a lateness flag shows when a releasable frame has been kept waiting too long.

Top module: `vl_regulator`

## Requirements
- R1: After reset, both port release strobes, `busy`, `reject` and `late` are 0, and the spacing timer starts expired, so the first valid request is released without waiting.
- R2: A release drives `a_rel` and `b_rel` high in the same cycle, with equal sequence numbers and equal byte counts. The byte count is the frame length plus 20.
- R3: Consider a request sampled on clock edge n, and let the previous release be registered on edge r. The release is registered on edge max(n+1, r+G+1), where G = TICKS_PER_MS·2^k ticks, assuming a tick on every edge. Releases are therefore never closer together than G ticks. While the frame waits, `busy` is 1.
- R4: A request is rejected if its length is below 64, above 1518, or above `max_len`. The `reject` output pulses in the cycle after the request, and the frame is never released.
- R5: A request that arrives while a frame is held is rejected. The held frame is still released unchanged at its scheduled edge.
- R6: The first release after reset carries sequence number 0. Each later release carries the previous number plus 1, and 255 is followed by 1, never by 0.
- R7: A new `gap_exp` value applies only to the spacing interval that starts at the next release. The interval already running keeps the exponent that was latched at its own release.
- R8: While `tx_hold` is 1, nothing is released. `late` rises once a releasable frame has waited more than JITTER_TICKS ticks. Dropping `tx_hold` releases the frame on the next edge and clears `late`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| tick_us | input | 1 | one-microsecond time strobe |
| gap_exp | input | 3 | spacing exponent k, spacing 2^k ms |
| max_len | input | 11 | largest length accepted |
| tx_hold | input | 1 | defer releases while high |
| req | input | 1 | descriptor request strobe |
| req_len | input | 11 | frame length in bytes |
| busy | output | 1 | a descriptor is held |
| reject | output | 1 | last request refused |
| late | output | 1 | held frame waited too long after it became releasable |
| a_rel | output | 1 | release strobe, port A |
| a_seq | output | 8 | sequence number, port A |
| a_bytes | output | 11 | wire byte count, port A |
| b_rel | output | 1 | release strobe, port B |
| b_seq | output | 8 | sequence number, port B |
| b_bytes | output | 11 | wire byte count, port B |

## Verification
A request driven before edge n produces `reject` or a release visible right after edge n. Otherwise its release is due right after edge r+G+1, so the bench predicts the exact cycle number from the recorded cycle of the previous release. `busy` is due in the cycle after a held request. A drop of `tx_hold` shows its release one edge later. The bench drives inputs and samples outputs on the falling edge and compares its cycle counter against these predictions. With the spacing shortened through the ticks-per-ms parameter, the sequence-number wrap is reached inside the run.

// File: rtl/vl_regulator_pkg.sv
package vl_regulator_pkg;
  localparam int LEN_W      = 11;
  localparam int SEQ_W      = 8;
  localparam int EXP_W      = 3;
  localparam int MIN_FRAME  = 64;
  localparam int MAX_FRAME  = 1518;
  localparam int WIRE_EXTRA = 20;

  function automatic logic [SEQ_W-1:0] seq_after(input logic [SEQ_W-1:0] s);
    return (s == 8'd255) ? 8'd1 : s + 8'd1;
  endfunction

  function automatic logic len_ok(input logic [LEN_W-1:0] len, input logic [LEN_W-1:0] cap);
    return (len >= LEN_W'(MIN_FRAME)) && (len <= LEN_W'(MAX_FRAME)) && (len <= cap);
  endfunction

  function automatic logic [LEN_W-1:0] wire_bytes(input logic [LEN_W-1:0] len);
    return len + LEN_W'(WIRE_EXTRA);
  endfunction

  function automatic int unsigned gap_ticks(input logic [EXP_W-1:0] e, input int unsigned tpm);
    return tpm << e;
  endfunction
endpackage

// File: rtl/vl_gap_timer.sv
module vl_gap_timer
  import vl_regulator_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000,
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [EXP_W-1:0] exp_cfg,
  output logic             open
);
  logic [CNT_W-1:0] elapsed;
  logic [EXP_W-1:0] cur_exp;
  logic             open_q;
  logic [CNT_W-1:0] last_tick;

  assign last_tick = CNT_W'(gap_ticks(cur_exp, int'(TICKS_PER_MS)) - 1);
  assign open = open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed <= '0;
      cur_exp <= '0;
      open_q  <= 1'b1;
    end else if (start) begin
      elapsed <= '0;
      cur_exp <= exp_cfg;
      open_q  <= 1'b0;
    end else if (tick && !open_q) begin
      elapsed <= elapsed + 1'b1;
      if (elapsed == last_tick) open_q <= 1'b1;
    end
  end

  p_open_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (open && !start) |=> open);
  p_closed_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !open);
endmodule

// File: rtl/vl_seq_gen.sv
module vl_seq_gen
  import vl_regulator_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [SEQ_W-1:0] seq
);
  logic [SEQ_W-1:0] seq_q;
  assign seq = seq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   seq_q <= '0;
    else if (adv) seq_q <= seq_after(seq_q);
  end

  p_no_zero_after_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (seq != '0));
endmodule

// File: rtl/vl_late_mon.sv
module vl_late_mon #(
  parameter int JITTER_TICKS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic waiting,
  input  logic clear,
  output logic late
);
  localparam int W_W = $clog2(JITTER_TICKS + 2);
  logic [W_W-1:0] wcnt;

  assign late = (wcnt > W_W'(JITTER_TICKS));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) wcnt <= '0;
    else if (waiting && tick && !late) wcnt <= wcnt + 1'b1;
  end

  p_late_needs_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late) |-> $past(waiting));
endmodule

// File: rtl/vl_regulator.sv
module vl_regulator
  import vl_regulator_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000,
  parameter int JITTER_TICKS = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_us,
  input  logic [2:0]       gap_exp,
  input  logic [10:0]      max_len,
  input  logic             tx_hold,
  input  logic             req,
  input  logic [10:0]      req_len,
  output logic             busy,
  output logic             reject,
  output logic             late,
  output logic             a_rel,
  output logic [7:0]       a_seq,
  output logic [10:0]      a_bytes,
  output logic             b_rel,
  output logic [7:0]       b_seq,
  output logic [10:0]      b_bytes
);
  localparam int NPORTS = 2;
  localparam int CNT_W  = $clog2(TICKS_PER_MS * 128 + 1);

  logic             gap_open, fire, accept, req_good;
  logic             pend_q, reject_q;
  logic [LEN_W-1:0] pend_len, rel_len;
  logic [SEQ_W-1:0] seq_now;

  logic             prt_rel   [NPORTS];
  logic [SEQ_W-1:0] prt_seq   [NPORTS];
  logic [LEN_W-1:0] prt_bytes [NPORTS];

  assign req_good = len_ok(req_len, max_len);
  assign accept   = req && req_good && !pend_q;
  assign fire     = (pend_q || accept) && gap_open && !tx_hold;
  assign rel_len  = pend_q ? pend_len : req_len;

  vl_gap_timer #(.TICKS_PER_MS(TICKS_PER_MS), .CNT_W(CNT_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .start(fire),
    .exp_cfg(gap_exp), .open(gap_open));

  vl_seq_gen u_seq (.clk(clk), .rst_n(rst_n), .adv(fire), .seq(seq_now));

  vl_late_mon #(.JITTER_TICKS(JITTER_TICKS)) u_late (
    .clk(clk), .rst_n(rst_n), .tick(tick_us),
    .waiting(pend_q && gap_open), .clear(fire), .late(late));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      pend_len <= '0;
      reject_q <= 1'b0;
    end else begin
      reject_q <= req && (!req_good || pend_q);
      if (fire)        pend_q <= 1'b0;
      else if (accept) begin
        pend_q   <= 1'b1;
        pend_len <= req_len;
      end
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prt_rel[p]   <= 1'b0;
        prt_seq[p]   <= '0;
        prt_bytes[p] <= '0;
      end else begin
        prt_rel[p] <= fire;
        if (fire) begin
          prt_seq[p]   <= seq_now;
          prt_bytes[p] <= wire_bytes(rel_len);
        end
      end
    end
  end

  assign busy    = pend_q;
  assign reject  = reject_q;
  assign a_rel   = prt_rel[0];
  assign a_seq   = prt_seq[0];
  assign a_bytes = prt_bytes[0];
  assign b_rel   = prt_rel[1];
  assign b_seq   = prt_seq[1];
  assign b_bytes = prt_bytes[1];

  // checker state: ticks since the last release and the exponent it latched
  logic [CNT_W:0]   chk_ticks;
  logic [EXP_W-1:0] chk_exp;
  logic             chk_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_ticks <= '0;
      chk_exp   <= '0;
      chk_seen  <= 1'b0;
    end else if (fire) begin
      chk_ticks <= '0;
      chk_exp   <= gap_exp;
      chk_seen  <= 1'b1;
    end else if (tick_us && !chk_ticks[CNT_W]) begin
      chk_ticks <= chk_ticks + 1'b1;
    end
  end

  p_min_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && chk_seen) |-> (chk_ticks >= (CNT_W+1)'(gap_ticks(chk_exp, int'(TICKS_PER_MS)))));
  p_twin_ports_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rel == b_rel) && (!a_rel || (a_seq == b_seq && a_bytes == b_bytes)));
  p_bad_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !len_ok(req_len, max_len)) |=> reject);
  p_busy_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && busy) |=> reject);
  p_hold_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hold |=> !a_rel);
  p_late_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    late |-> busy);
endmodule

// File: tb/vl_regulator_test.sv
module vl_regulator_test;
  localparam int TPM = 10;
  localparam int JIT = 500;

  logic        clk = 1'b0, rst_n = 1'b0, tick_us = 1'b1, tx_hold = 1'b0, req = 1'b0;
  logic [2:0]  gap_exp = 3'd0;
  logic [10:0] max_len = 11'd1518, req_len = 11'd0;
  logic        busy, reject, late, a_rel, b_rel;
  logic [7:0]  a_seq, b_seq;
  logic [10:0] a_bytes, b_bytes;

  int total = 0, bad = 0, cyc = 0;
  int last_r = 0, last_exp = 0;
  bit have_prev = 0;
  logic [7:0] nseq = 8'd0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vl_regulator #(.TICKS_PER_MS(TPM), .JITTER_TICKS(JIT)) uut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .gap_exp(gap_exp), .max_len(max_len),
    .tx_hold(tx_hold), .req(req), .req_len(req_len), .busy(busy), .reject(reject),
    .late(late), .a_rel(a_rel), .a_seq(a_seq), .a_bytes(a_bytes), .b_rel(b_rel),
    .b_seq(b_seq), .b_bytes(b_bytes));

  function automatic bit exp_ok(int len, int cap);
    return len >= 64 && len <= 1518 && len <= cap;
  endfunction
  function automatic logic [7:0] exp_next(logic [7:0] s);
    return (s == 8'hFF) ? 8'h01 : s + 8'h01;
  endfunction

  task automatic chk(bit cond, string tag, int act, int expv);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic note_release();
    chk(a_seq == nseq, "R6 sequence", a_seq, nseq);
    if (have_prev && nseq == 8'd1) chk(a_seq != 8'd0, "R6 wrap skips zero", a_seq, 1);
    chk(b_rel && b_seq == a_seq && b_bytes == a_bytes, "R2 twin ports", b_seq, a_seq);
    last_r = cyc; last_exp = gap_exp; have_prev = 1; nseq = exp_next(nseq);
  endtask

  task automatic frame(int len, int delay, string ttag);
    int n, due;
    repeat (delay) @(negedge clk);
    n = cyc;
    due = n + 1;
    if (have_prev && last_r + (TPM << last_exp) + 1 > due) due = last_r + (TPM << last_exp) + 1;
    req = 1'b1; req_len = 11'(len);
    @(negedge clk);
    req = 1'b0;
    if (!exp_ok(len, max_len)) begin
      chk(reject == 1'b1, "R4 reject pulse", reject, 1);
      chk(a_rel == 1'b0, "R4 no release", a_rel, 0);
    end else begin
      if (due > n + 1) chk(busy == 1'b1, "R3 busy while held", busy, 1);
      while (!a_rel && cyc < n + 5000) @(negedge clk);
      chk(cyc == due, ttag, cyc, due);
      chk(a_bytes == 11'(len + 20), "R2 wire bytes", a_bytes, len + 20);
      note_release();
    end
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog R3 actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!a_rel && !b_rel && !busy && !reject && !late, "R1 reset outputs", a_rel, 0);
    frame(100, 0, "R1 first release immediate");
    frame(200, 0, "R3 held until gap");
    frame(64, 0, "R3 min length");
    frame(1518, 3, "R3 max length");
    frame(63, 0, "R4 short");
    frame(1519, 0, "R4 long");
    max_len = 11'd500;
    frame(600, 0, "R4 over cap");
    frame(500, 0, "R3 at cap");
    max_len = 11'd1518;
    frame(300, 40, "R3 open gap next cycle");

    // R7: exponent change waits for the running interval
    frame(128, 0, "R3 before change");
    gap_exp = 3'd2;
    frame(129, 0, "R7 old interval kept");
    frame(130, 0, "R7 new interval used");
    gap_exp = 3'd0;
    frame(131, 0, "R7 next after change back");
    frame(132, 0, "R3 back to short gap");

    // R5: request while busy is refused, held frame unchanged
    begin
      int n, due;
      n = cyc; due = last_r + (TPM << last_exp) + 1;
      req = 1'b1; req_len = 11'd210;
      @(negedge clk);
      req_len = 11'd310;
      @(negedge clk);
      req = 1'b0;
      chk(reject == 1'b1, "R5 busy reject", reject, 1);
      while (!a_rel && cyc < n + 5000) @(negedge clk);
      chk(cyc == due, "R5 held timing", cyc, due);
      chk(a_bytes == 11'd230, "R5 held frame kept", a_bytes, 230);
      note_release();
    end

    // R8: hold defers release and raises late
    begin
      bit leaked;
      leaked = 0;
      tx_hold = 1'b1;
      req = 1'b1; req_len = 11'd400;
      @(negedge clk);
      req = 1'b0;
      repeat (TPM + 100) begin @(negedge clk); if (a_rel) leaked = 1; end
      chk(late == 1'b0, "R8 not yet late", late, 0);
      chk(busy == 1'b1, "R8 still busy", busy, 1);
      repeat (JIT + 50) begin @(negedge clk); if (a_rel) leaked = 1; end
      chk(late == 1'b1, "R8 late raised", late, 1);
      chk(!leaked, "R8 nothing released under hold", leaked, 0);
      tx_hold = 1'b0;
      @(negedge clk);
      chk(a_rel == 1'b1, "R8 release after hold", a_rel, 1);
      chk(late == 1'b0, "R8 late cleared", late, 0);
      chk(a_bytes == 11'd420, "R8 bytes", a_bytes, 420);
      note_release();
    end

    // random mix
    for (int i = 0; i < 60; i++) begin
      int l;
      l = 40 + int'($urandom_range(0, 1560));
      if (i % 9 == 0) gap_exp = 3'($urandom_range(0, 1));
      frame(l, int'($urandom_range(0, 25)), "R3 random timing");
    end
    gap_exp = 3'd0;

    // R6: run through the sequence wrap
    for (int i = 0; i < 260; i++) frame(64 + (i % 90), 0, "R6 wrap run timing");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule